// File: doc/BRIEF.md
# H-Bridge Mode Decoder and Fault Supervisor

This block sits between two direction pins and one H-bridge power stage. It turns the pin pair into one of four bridge modes: coast with the outputs floating, reverse, forward and brake. It also gates the bridge off when a protection monitor requires it, and it drives the one active-low fault line that a host processor watches. When the bridge leaves an idle or braking state for a driving direction, it sends a one-cycle request to the PWM duty engine so that the duty cycle ramps up from zero.

Each analog monitor reaches the block as an asynchronous digital flag: current limit, FET overcurrent, over-temperature and supply undervoltage. Every flag passes through a two-flop synchronizer, and each flag follows its own fault policy. Overcurrent must survive a short deglitch window, and it then latches until the next power-on reset. Over-temperature and undervoltage stop the bridge only while they are present. Undervoltage also clears the internal timers. A current limit that persists for a long window is reported without stopping the bridge, and entering sleep clears it. Each exit from sleep lowers the fault line for a fixed number of cycles. All window lengths are parameters counted in clock cycles.

Top module: `hbs_top`

## Requirements
- R1: The synchronized pin pair {dir_a_i, dir_b_i} selects the mode on mode_o. 2'b10 gives forward, 2'b01 gives reverse, 2'b11 gives brake, and bridge_en_o is 1 in all three. mode_o uses the same 2-bit codes, and 2'b00 is coast.
- R2: When both pins are low, mode_o reads 2'b00 (coast) and bridge_en_o is 0.
- R3: Each change from both pins low to any other pin value drives fault_n_o low for exactly WAKE_PULSE_CYC cycles, provided no other fault is present.
- R4: softstart_o pulses high for one cycle when the effective mode changes from coast or brake to forward or reverse. No pulse is produced between forward and reverse, or when entering brake.
- R5: A current-limit flag held continuously for ILIM_FAULT_CYC synchronized cycles drives fault_n_o low. bridge_en_o stays 1 throughout, and fault_n_o returns high within a few cycles after the flag drops.
- R6: Entering sleep releases a pending current-limit fault even if the flag is still high.
- R7: An overcurrent flag that is shorter than OCP_DEGLITCH_CYC cycles has no effect on bridge_en_o or fault_n_o.
- R8: An overcurrent flag held for OCP_DEGLITCH_CYC cycles forces bridge_en_o to 0, mode_o to coast and fault_n_o to 0. This state persists after the flag drops and after any pin change, until rst_i is applied.
- R9: The over-temperature flag forces bridge_en_o to 0 and fault_n_o to 0 while it is present. When it clears, the bridge returns to the pin-selected mode and a soft-start request is issued.
- R10: The undervoltage flag forces bridge_en_o to 0 and fault_n_o to 0 while it is present. It also restarts the current-limit persistence count.
- R11: While rst_i is high and on the cycle after it falls, the outputs read mode_o 2'b00, bridge_en_o 0, fault_n_o 1 and softstart_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset; stands for power-on |
| dir_a_i | input | 1 | Direction pin A, asynchronous |
| dir_b_i | input | 1 | Direction pin B, asynchronous |
| ilim_i | input | 1 | Current-limit comparator flag, asynchronous |
| ocp_i | input | 1 | FET overcurrent flag, asynchronous |
| otemp_i | input | 1 | Over-temperature flag, asynchronous |
| uvlo_i | input | 1 | Undervoltage flag, asynchronous |
| mode_o | output | 2 | Effective bridge mode: 00 coast, 01 reverse, 10 forward, 11 brake |
| bridge_en_o | output | 1 | Bridge drivers enabled |
| fault_n_o | output | 1 | Active-low fault indication |
| softstart_o | output | 1 | One-cycle request to restart the PWM duty from zero |

## Verification
A single step out of sleep into a driving direction starts the wake fault pulse and the soft-start request in the same cycle. The bench makes that step and counts both events independently: it expects a fault-low run of exactly WAKE_PULSE_CYC cycles and exactly one soft-start cycle. A second collision happens when the pins drop to sleep while a current-limit fault is active and its flag is still high. In that cycle the sleep clear must win over the continued count, and the bench observes the fault line released at the pins. The bench also resumes from an undervoltage pause partway through a current-limit window and checks that the window restarts instead of carrying its earlier count over.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  typedef enum logic [1:0] {
    HB_COAST   = 2'b00,
    HB_REVERSE = 2'b01,
    HB_FORWARD = 2'b10,
    HB_BRAKE   = 2'b11
  } hb_mode_t;

  // A driving mode pushes current through the winding in one direction.
  function automatic logic is_drive(hb_mode_t m);
    return (m == HB_FORWARD) || (m == HB_REVERSE);
  endfunction

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/hbs_persist.sv
// Raises hit_o once cond_i has been high for HOLD_CYC consecutive cycles;
// any low cycle or clr_i restarts the count and drops hit_o.
module hbs_persist #(
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic cond_i,
  output logic hit_o
);

  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          hit_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i || !cond_i) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      hit_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_o = hit_q;

endmodule

// File: rtl/hbs_wake_pulse.sv
// Holds active_o for PULSE_CYC cycles starting at the cycle after trig_i.
module hbs_wake_pulse #(
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic trig_i,
  output logic active_o
);

  localparam int unsigned CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i)       cnt_q <= '0;
    else if (trig_i)          cnt_q <= CW'(PULSE_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

endmodule

// File: rtl/hbs_top.sv
module hbs_top
  import hbs_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ      = 250_000_000,
  parameter int unsigned SYNC_STAGES      = 2,
  parameter int unsigned OCP_DEGLITCH_CYC = (CLK_FREQ_HZ / 1_000_000) * 3,
  parameter int unsigned ILIM_FAULT_CYC   = (CLK_FREQ_HZ / 1_000) * 275,
  parameter int unsigned WAKE_PULSE_CYC   = CLK_FREQ_HZ / 1_000_000
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       dir_a_i,
  input  logic       dir_b_i,
  input  logic       ilim_i,
  input  logic       ocp_i,
  input  logic       otemp_i,
  input  logic       uvlo_i,
  output logic [1:0] mode_o,
  output logic       bridge_en_o,
  output logic       fault_n_o,
  output logic       softstart_o
);

  localparam int unsigned NFLAG = 6;

  // Synchronized inputs
  logic [NFLAG-1:0] raw_flags, syn_flags;
  logic             dir_a_s, dir_b_s, ilim_s, ocp_s, ot_s, uv_s;

  assign raw_flags = {dir_a_i, dir_b_i, ilim_i, ocp_i, otemp_i, uvlo_i};

  hbs_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw_flags),
    .q_o   (syn_flags)
  );

  assign {dir_a_s, dir_b_s, ilim_s, ocp_s, ot_s, uv_s} = syn_flags;

  // Pin decode
  hb_mode_t req_mode;
  logic     sleep_req;

  assign req_mode  = hb_mode_t'({dir_a_s, dir_b_s});
  assign sleep_req = (req_mode == HB_COAST);

  // Overcurrent: deglitch, then latch until power-on reset
  logic ocp_hit, ocp_latch;

  hbs_persist #(.HOLD_CYC(OCP_DEGLITCH_CYC)) u_ocp_glitch (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (uv_s),
    .cond_i (ocp_s),
    .hit_o  (ocp_hit)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)        ocp_latch <= 1'b0;
    else if (ocp_hit) ocp_latch <= 1'b1;
  end

  // Current limit: long persistence, report only, cleared by sleep
  logic ilim_hit;

  hbs_persist #(.HOLD_CYC(ILIM_FAULT_CYC)) u_ilim_timer (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (sleep_req | uv_s),
    .cond_i (ilim_s),
    .hit_o  (ilim_hit)
  );

  // Sleep-exit fault pulse
  logic sleep_q, wake_act;

  always_ff @(posedge clk_i) begin
    if (rst_i) sleep_q <= 1'b1;
    else       sleep_q <= sleep_req;
  end

  hbs_wake_pulse #(.PULSE_CYC(WAKE_PULSE_CYC)) u_wake (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .clr_i    (uv_s),
    .trig_i   (sleep_q & ~sleep_req),
    .active_o (wake_act)
  );

  // Effective mode and fault merge
  logic     halt;
  hb_mode_t mode_next, mode_q;
  logic     fault_any;
  logic     en_q, fault_n_q, ss_q;

  assign halt      = ocp_latch | ot_s | uv_s;
  assign mode_next = (halt || sleep_req) ? HB_COAST : req_mode;
  assign fault_any = ocp_latch | ot_s | uv_s | ilim_hit | wake_act;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q    <= HB_COAST;
      en_q      <= 1'b0;
      fault_n_q <= 1'b1;
      ss_q      <= 1'b0;
    end else begin
      mode_q    <= mode_next;
      en_q      <= (mode_next != HB_COAST);
      fault_n_q <= ~fault_any;
      ss_q      <= is_drive(mode_next) && !is_drive(mode_q);
    end
  end

  assign mode_o      = mode_q;
  assign bridge_en_o = en_q;
  assign fault_n_o   = fault_n_q;
  assign softstart_o = ss_q;

endmodule

// File: rtl/hbs_checker.sv
module hbs_checker (
  input logic       clk_i,
  input logic       rst_i,
  input logic [1:0] mode_o,
  input logic       bridge_en_o,
  input logic       fault_n_o,
  input logic       softstart_o,
  input logic       ocp_latch,
  input logic       ot_s,
  input logic       uv_s
);

  AST_COAST_DISABLED: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_o == 2'b00) |-> !bridge_en_o); // R2

  AST_SS_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    softstart_o |=> !softstart_o); // R4

  AST_SS_DRIVING: assert property (@(posedge clk_i) disable iff (rst_i)
    softstart_o |-> (mode_o == 2'b01 || mode_o == 2'b10)); // R4

  AST_OCP_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    ocp_latch |=> ocp_latch); // R8

  AST_OCP_HALT: assert property (@(posedge clk_i) disable iff (rst_i)
    (ocp_latch && $past(ocp_latch)) |-> (!bridge_en_o && !fault_n_o)); // R8

  AST_THERMAL_HALT: assert property (@(posedge clk_i) disable iff (rst_i)
    (ot_s && $past(ot_s)) |-> (!bridge_en_o && !fault_n_o)); // R9

  AST_UVLO_HALT: assert property (@(posedge clk_i) disable iff (rst_i)
    (uv_s && $past(uv_s)) |-> (!bridge_en_o && !fault_n_o)); // R10

endmodule

bind hbs_top hbs_checker u_hbs_checker (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .mode_o      (mode_o),
  .bridge_en_o (bridge_en_o),
  .fault_n_o   (fault_n_o),
  .softstart_o (softstart_o),
  .ocp_latch   (ocp_latch),
  .ot_s        (ot_s),
  .uv_s        (uv_s)
);

// File: tb/tb_hbs_top.sv
`timescale 1ns/1ps
module tb_hbs_top;

  localparam int unsigned OCP_N  = 6;
  localparam int unsigned ILIM_N = 40;
  localparam int unsigned WAKE_N = 5;

  logic clk = 1'b0;
  logic rst;
  logic dir_a, dir_b, ilim, ocp, otemp, uvlo;
  logic [1:0] mode;
  logic en, fault_n, ss;

  always #2 clk = ~clk;

  hbs_top #(
    .OCP_DEGLITCH_CYC (OCP_N),
    .ILIM_FAULT_CYC   (ILIM_N),
    .WAKE_PULSE_CYC   (WAKE_N)
  ) dut (
    .clk_i       (clk),
    .rst_i       (rst),
    .dir_a_i     (dir_a),
    .dir_b_i     (dir_b),
    .ilim_i      (ilim),
    .ocp_i       (ocp),
    .otemp_i     (otemp),
    .uvlo_i      (uvlo),
    .mode_o      (mode),
    .bridge_en_o (en),
    .fault_n_o   (fault_n),
    .softstart_o (ss)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int ss_cnt = 0;
  int flt_cnt = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (ss) ss_cnt++;
      if (!fault_n) flt_cnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_dir(input logic a, input logic b);
    @(negedge clk);
    dir_a = a;
    dir_b = b;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    dir_a = 0; dir_b = 0; ilim = 0; ocp = 0; otemp = 0; uvlo = 0;
    cyc(5);
    chk("R11 mode in reset", mode, 0);
    rst = 1'b0;
    cyc(1);
    chk("R11 mode", mode, 0);
    chk("R11 enable", en, 0);
    chk("R11 fault_n", fault_n, 1);
    chk("R11 softstart", ss, 0);
  endtask

  task automatic t_modes();
    int s0, f0;
    s0 = ss_cnt; f0 = flt_cnt;
    set_dir(1, 0);
    cyc(14);
    chk("R1 forward mode", mode, 2);
    chk("R1 forward enable", en, 1);
    chk("R3 wake pulse width", flt_cnt - f0, WAKE_N);
    chk("R4 softstart from sleep", ss_cnt - s0, 1);
    s0 = ss_cnt; f0 = flt_cnt;
    set_dir(0, 1);
    cyc(6);
    chk("R1 reverse mode", mode, 1);
    chk("R4 no softstart fwd->rev", ss_cnt - s0, 0);
    set_dir(1, 1);
    cyc(6);
    chk("R1 brake mode", mode, 3);
    chk("R1 brake enable", en, 1);
    chk("R4 no softstart into brake", ss_cnt - s0, 0);
    set_dir(0, 1);
    cyc(6);
    chk("R4 softstart brake->rev", ss_cnt - s0, 1);
    chk("R3 no pulse without sleep", flt_cnt - f0, 0);
    set_dir(0, 0);
    cyc(6);
    chk("R2 sleep mode", mode, 0);
    chk("R2 sleep enable", en, 0);
  endtask

  task automatic t_ilim();
    set_dir(1, 0);
    cyc(15);
    @(negedge clk); ilim = 1;
    cyc(34);
    chk("R5 not yet faulted", fault_n, 1);
    cyc(16);
    chk("R5 fault after persistence", fault_n, 0);
    chk("R5 bridge keeps running", en, 1);
    @(negedge clk); ilim = 0;
    cyc(6);
    chk("R5 self release", fault_n, 1);
    @(negedge clk); ilim = 1;
    cyc(50);
    chk("R6 fault before sleep", fault_n, 0);
    set_dir(0, 0);
    cyc(6);
    chk("R6 cleared by sleep", fault_n, 1);
    @(negedge clk); ilim = 0;
  endtask

  task automatic t_uvlo();
    set_dir(1, 0);
    cyc(15);
    @(negedge clk); ilim = 1;
    cyc(30);
    @(negedge clk); uvlo = 1;
    cyc(4);
    chk("R10 disabled", en, 0);
    chk("R10 fault", fault_n, 0);
    uvlo = 0;
    cyc(20);
    chk("R10 timer restarted", fault_n, 1);
    chk("R10 resumed", en, 1);
    cyc(40);
    chk("R10 fresh window elapses", fault_n, 0);
    @(negedge clk); ilim = 0;
    cyc(6);
  endtask

  task automatic t_thermal();
    int s0;
    @(negedge clk); otemp = 1;
    cyc(5);
    chk("R9 disabled", en, 0);
    chk("R9 fault", fault_n, 0);
    chk("R9 coast", mode, 0);
    s0 = ss_cnt;
    otemp = 0;
    cyc(6);
    chk("R9 resumed", en, 1);
    chk("R9 fault released", fault_n, 1);
    chk("R9 mode back", mode, 2);
    chk("R9 softstart on resume", ss_cnt - s0, 1);
  endtask

  task automatic t_ocp();
    @(negedge clk); ocp = 1;
    cyc(3);
    ocp = 0;
    cyc(10);
    chk("R7 glitch ignored enable", en, 1);
    chk("R7 glitch ignored fault", fault_n, 1);
    @(negedge clk); ocp = 1;
    cyc(12);
    ocp = 0;
    cyc(20);
    chk("R8 latched enable", en, 0);
    chk("R8 latched fault", fault_n, 0);
    chk("R8 latched mode", mode, 0);
    set_dir(0, 1);
    cyc(10);
    chk("R8 pins do not clear", en, 0);
    do_reset();
    set_dir(1, 0);
    cyc(15);
    chk("R8 reset clears enable", en, 1);
    chk("R8 reset clears fault", fault_n, 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    rst = 1'b1;
    dir_a = 0; dir_b = 0; ilim = 0; ocp = 0; otemp = 0; uvlo = 0;
    do_reset();
    t_modes();
    t_ilim();
    t_uvlo();
    t_thermal();
    t_ocp();
    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual 0 expected 1");
      summary();
    end
  end

endmodule